// File: doc/BRIEF.md
# Paged Effective Address Generator

This block resolves the memory operand address for a machine with 12-bit words and 12-bit native addresses, whose instructions carry only a short page offset. Given an instruction word, the address of that instruction and a memory-field register, it produces a 15-bit physical word address. A direct reference names a word either in page zero or in the page that holds the instruction. Each page is 128 words. An indirect reference first reads a 12-bit pointer from that page word and then uses the pointer as the address within the current field.

The 3-bit field register sits above the 12-bit address and opens eight fields of 4096 words, 32K words in total. Software loads it with an I/O-class command before an indirect instruction that has to reach outside the current 4K field. Pointer words are read through a simple request/data port to a word-wide memory. Each resolution ends with a one-cycle address-valid strobe.

Top module: `paged_ea_gen`

## Requirements
- R1: After synchronous reset, ea_valid, mem_rd_req and busy are 0, and the field register is 0, so the first resolution after reset has physical bits 14:12 equal to 0.
- R2: Instruction bit 8 (bit 11 is the MSB) selects indirect when 1. Bit 7 selects the current page when 1 and page zero when 0. Bits 6:0 are the word offset. Bits 11:9, the opcode, have no effect on any address.
- R3: With bit 7 = 0, address bits 11:7 of the referenced page word are 0 and bits 6:0 equal the offset.
- R4: With bit 7 = 1, address bits 11:7 of the page word equal bits 11:7 of instr_pc, the address of the instruction being executed.
- R5: A direct request accepted at a clock edge gives ea_valid high for exactly the next cycle. ea_addr is {field, page word address}, and no memory read is issued.
- R6: An indirect request accepted at a clock edge raises mem_rd_req from the next cycle, with mem_rd_addr = {field, page word address}. Both are held unchanged until mem_rd_valid is sampled high.
- R7: In the cycle after mem_rd_valid is sampled high during a pointer read, ea_valid is high for one cycle with ea_addr = {field, mem_rd_data}.
- R8: A cycle with fld_wr high loads fld_data into the 3-bit field register at the clock edge. A request accepted at that same edge still uses the previous field. Later requests use the new field as physical bits 14:12.
- R9: busy is high from the cycle after acceptance through the ea_valid cycle. A req_valid seen while busy is ignored.
- R10: mem_rd_valid has no effect unless a pointer read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a resolution (taken when not busy) |
| instr | input | 12 | Instruction word |
| instr_pc | input | 12 | Address of the instruction being executed |
| fld_wr | input | 1 | Load the field register |
| fld_data | input | 3 | New field value |
| mem_rd_req | output | 1 | Pointer read request |
| mem_rd_addr | output | 15 | Pointer word physical address |
| mem_rd_valid | input | 1 | Pointer read data valid |
| mem_rd_data | input | 12 | Pointer word |
| busy | output | 1 | Resolution in progress |
| ea_valid | output | 1 | Resolved address strobe |
| ea_addr | output | 15 | Resolved physical word address |

## Verification
A direct resolution is due one cycle after the accepting edge. A pointer read request is due one cycle after acceptance, and an indirect result is due one cycle after the edge that samples mem_rd_valid. The bench drives every input on the falling edge and reads the outputs on the next falling edge. Each result is therefore checked in the single cycle it is due, and also in the waiting cycles and the cycle after, to show that the strobe has neither come early nor stayed high. Pointer data is returned after varied delays, to show that the read address holds steady while it waits.

// File: rtl/peg_pkg.sv
package peg_pkg;
    localparam int WORD_W  = 12;
    localparam int FIELD_W = 3;
    localparam int OFFS_W  = 7;
    localparam int IND_POS  = 8;
    localparam int PAGE_POS = 7;
    localparam int PHYS_W  = FIELD_W + WORD_W;
    localparam int PAGE_W  = WORD_W - OFFS_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } peg_state_e;

    typedef struct packed {
        logic              indirect;
        logic [PHYS_W-1:0] phys;
    } peg_ref_t;

    function automatic logic [WORD_W-1:0] page_word(
        input logic [WORD_W-1:0] ins,
        input logic [WORD_W-1:0] pc
    );
        logic [PAGE_W-1:0] hi;
        hi = ins[PAGE_POS] ? pc[WORD_W-1:OFFS_W] : '0;
        return {hi, ins[OFFS_W-1:0]};
    endfunction
endpackage

// File: rtl/peg_field_reg.sv
module peg_field_reg
    import peg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [FIELD_W-1:0] din,
    output logic [FIELD_W-1:0] field
);
    always_ff @(posedge clk) begin
        if (rst)
            field <= '0;
        else if (wr)
            field <= din;
    end
endmodule

// File: rtl/peg_decode.sv
module peg_decode
    import peg_pkg::*;
(
    input  logic [WORD_W-1:0]  instr,
    input  logic [WORD_W-1:0]  pc,
    input  logic [FIELD_W-1:0] field,
    output peg_ref_t           ref_o
);
    logic unused_bits;
    assign unused_bits = ^{instr[WORD_W-1:IND_POS+1], pc[OFFS_W-1:0]};

    always_comb begin
        ref_o.indirect = instr[IND_POS];
        ref_o.phys     = {field, page_word(instr, pc)};
    end
endmodule

// File: rtl/peg_seq.sv
module peg_seq
    import peg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  peg_ref_t          ref_i,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_req,
    output logic [PHYS_W-1:0] rd_addr,
    output logic              busy,
    output logic              ea_valid,
    output logic [PHYS_W-1:0] ea_addr
);
    peg_state_e        state;
    logic [PHYS_W-1:0] rd_addr_q;
    logic [PHYS_W-1:0] ea_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rd_addr_q <= '0;
            ea_q      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (ref_i.indirect) begin
                            rd_addr_q <= ref_i.phys;
                            state     <= ST_WAIT;
                        end else begin
                            ea_q  <= ref_i.phys;
                            state <= ST_DONE;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rd_valid) begin
                        ea_q  <= {rd_addr_q[PHYS_W-1:WORD_W], rd_data};
                        state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_req   = (state == ST_WAIT);
    assign rd_addr  = rd_addr_q;
    assign busy     = (state != ST_IDLE);
    assign ea_valid = (state == ST_DONE);
    assign ea_addr  = ea_q;
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
    import peg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [WORD_W-1:0]  instr,
    input  logic [WORD_W-1:0]  instr_pc,
    input  logic               fld_wr,
    input  logic [FIELD_W-1:0] fld_data,
    output logic               mem_rd_req,
    output logic [PHYS_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [WORD_W-1:0]  mem_rd_data,
    output logic               busy,
    output logic               ea_valid,
    output logic [PHYS_W-1:0]  ea_addr
);
    logic [FIELD_W-1:0] field;
    peg_ref_t           dref;

    peg_field_reg u_field (
        .clk   (clk),
        .rst   (rst),
        .wr    (fld_wr),
        .din   (fld_data),
        .field (field)
    );

    peg_decode u_dec (
        .instr (instr),
        .pc    (instr_pc),
        .field (field),
        .ref_o (dref)
    );

    peg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ref_i     (dref),
        .rd_valid  (mem_rd_valid),
        .rd_data   (mem_rd_data),
        .rd_req    (mem_rd_req),
        .rd_addr   (mem_rd_addr),
        .busy      (busy),
        .ea_valid  (ea_valid),
        .ea_addr   (ea_addr)
    );
endmodule

// File: rtl/peg_checker.sv
module peg_checker
    import peg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [WORD_W-1:0]  instr,
    input logic [WORD_W-1:0]  instr_pc,
    input logic               fld_wr,
    input logic [FIELD_W-1:0] fld_data,
    input logic               mem_rd_req,
    input logic [PHYS_W-1:0]  mem_rd_addr,
    input logic               mem_rd_valid,
    input logic [WORD_W-1:0]  mem_rd_data,
    input logic               busy,
    input logic               ea_valid,
    input logic [PHYS_W-1:0]  ea_addr
);
    logic unused_chk;
    assign unused_chk = ^{instr_pc, fld_wr, fld_data};

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        ea_valid |=> !ea_valid);

    a_r5_direct_latency: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !instr[IND_POS]) |=> (ea_valid && !mem_rd_req));

    a_r3_page_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !instr[IND_POS] && !instr[PAGE_POS])
        |=> (ea_addr[WORD_W-1:OFFS_W] == '0));

    a_r6_read_start: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && instr[IND_POS]) |=> (mem_rd_req && !ea_valid));

    a_r6_read_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    a_r7_pointer_used: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_valid)
        |=> (ea_valid && ea_addr[WORD_W-1:0] == $past(mem_rd_data)));

    a_r9_busy_cover: assert property (@(posedge clk) disable iff (rst)
        (ea_valid || mem_rd_req) |-> busy);

    a_r10_stray_valid: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> !busy);
endmodule

bind paged_ea_gen peg_checker u_chk (.*);

// File: tb/paged_ea_gen_test.sv
module paged_ea_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [11:0] instr = '0;
    logic [11:0] instr_pc = '0;
    logic        fld_wr = 1'b0;
    logic [2:0]  fld_data = '0;
    logic        mem_rd_req;
    logic [14:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [11:0] mem_rd_data = '0;
    logic        busy;
    logic        ea_valid;
    logic [14:0] ea_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // vector columns: field, instr, pc, pointer data, read delay, expected read addr, expected address
    localparam logic [2:0]  V_FLD [NVEC] = '{3'd0, 3'd3, 3'd5, 3'd7, 3'd2, 3'd0};
    localparam logic [11:0] V_INS [NVEC] = '{12'h205, 12'h4AA, 12'h17F, 12'hF80, 12'h0FF, 12'h1C1};
    localparam logic [11:0] V_PC  [NVEC] = '{12'h3A7, 12'hABC, 12'h123, 12'hFFF, 12'h07F, 12'h200};
    localparam logic [11:0] V_DAT [NVEC] = '{12'h000, 12'h000, 12'hFED, 12'h000, 12'h000, 12'h8C3};
    localparam int          V_DLY [NVEC] = '{0, 0, 0, 3, 0, 1};
    localparam logic [14:0] V_RDA [NVEC] = '{15'h0, 15'h0, 15'h507F, 15'h7F80, 15'h0, 15'h0241};
    localparam logic [14:0] V_EA  [NVEC] = '{15'h0005, 15'h3AAA, 15'h5FED, 15'h7000, 15'h207F, 15'h08C3};

    paged_ea_gen uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_field(input logic [2:0] f);
        @(negedge clk);
        fld_wr = 1'b1; fld_data = f;
        @(negedge clk);
        fld_wr = 1'b0;
    endtask

    // drive a request; returns at the negedge after the accepting edge
    task automatic issue(input logic [11:0] ins, input logic [11:0] pc);
        @(negedge clk);
        req_valid = 1'b1; instr = ins; instr_pc = pc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic give_data(input logic [11:0] d);
        mem_rd_valid = 1'b1; mem_rd_data = d;
        @(negedge clk);
        mem_rd_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(!ea_valid && !mem_rd_req && !busy, "R1 reset outputs", {13'd0, busy, mem_rd_req, ea_valid}, 16'h0);

        // R1, R4: first direct reference after reset uses field 0
        issue(12'h0C0, 12'h555);
        check(ea_valid && ea_addr == 15'h0540, "R1 R4 field zero after reset", {1'b0, ea_addr}, 16'h0540);
        @(negedge clk);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            load_field(V_FLD[i]);
            issue(V_INS[i], V_PC[i]);
            if (V_INS[i][8]) begin
                check(mem_rd_req && !ea_valid && mem_rd_addr == V_RDA[i], "R6 pointer read address",
                      {1'b0, mem_rd_addr}, {1'b0, V_RDA[i]});
                for (int d = 0; d < V_DLY[i]; d++) begin
                    @(negedge clk);
                    check(mem_rd_req && !ea_valid && mem_rd_addr == V_RDA[i], "R6 read held while waiting",
                          {1'b0, mem_rd_addr}, {1'b0, V_RDA[i]});
                end
                give_data(V_DAT[i]);
                check(ea_valid && ea_addr == V_EA[i], "R7 indirect result", {1'b0, ea_addr}, {1'b0, V_EA[i]});
            end else begin
                check(ea_valid && !mem_rd_req && ea_addr == V_EA[i], "R5 R3 R4 direct result",
                      {1'b0, ea_addr}, {1'b0, V_EA[i]});
            end
            @(negedge clk);
            check(!ea_valid && !busy, "R5 strobe single cycle", {14'd0, busy, ea_valid}, 16'h0);
        end

        // R2: opcode bits do not change the address (field is 0 after last vector)
        issue(12'hE85, 12'h6C0);
        check(ea_valid && ea_addr == 15'h0685, "R2 opcode 7 ignored", {1'b0, ea_addr}, 16'h0685);
        @(negedge clk);
        issue(12'h085, 12'h6C0);
        check(ea_valid && ea_addr == 15'h0685, "R2 opcode 0 same address", {1'b0, ea_addr}, 16'h0685);
        @(negedge clk);

        // R8: field write at the accepting edge uses the previous field
        @(negedge clk);
        fld_wr = 1'b1; fld_data = 3'd6;
        req_valid = 1'b1; instr = 12'h011; instr_pc = 12'h000;
        @(negedge clk);
        fld_wr = 1'b0; req_valid = 1'b0;
        check(ea_valid && ea_addr == 15'h0011, "R8 same-edge load uses old field", {1'b0, ea_addr}, 16'h0011);
        @(negedge clk);
        issue(12'h011, 12'h000);
        check(ea_valid && ea_addr == 15'h6011, "R8 later request uses new field", {1'b0, ea_addr}, 16'h6011);
        @(negedge clk);

        // R9: request while busy is ignored
        issue(12'h1A0, 12'h880);
        check(busy && mem_rd_req && mem_rd_addr == 15'h68A0, "R9 busy during pointer read", {1'b0, mem_rd_addr}, 16'h68A0);
        req_valid = 1'b1; instr = 12'h003; instr_pc = 12'h000;
        @(negedge clk);
        req_valid = 1'b0;
        check(!ea_valid && mem_rd_req && mem_rd_addr == 15'h68A0, "R9 request while busy ignored",
              {1'b0, mem_rd_addr}, 16'h68A0);
        give_data(12'h123);
        check(ea_valid && busy && ea_addr == 15'h6123, "R9 original resolution completes", {1'b0, ea_addr}, 16'h6123);
        @(negedge clk);
        check(!busy && !ea_valid, "R9 idle after strobe", {15'd0, busy}, 16'h0);

        // R10: stray read-data valid while idle
        give_data(12'hABC);
        check(!ea_valid && !busy && !mem_rd_req, "R10 stray valid ignored", {14'd0, busy, ea_valid}, 16'h0);
        check(ea_addr == 15'h6123, "R10 result unchanged", {1'b0, ea_addr}, 16'h6123);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule